// File: doc/BRIEF.md
# Unaligned Byte-to-Word Write Packer

This block turns a write request expressed in bytes (a start byte address, a byte count and a stream of data bytes) into a run of 32-bit word program requests. Every request it issues goes to a word-aligned address. It is meant for a flash array that can only be programmed a whole word at a time.

Lanes of a word that the request does not cover are filled with all ones. Programming all ones leaves the existing flash bits as they are, so no read-modify-write is needed. The packer hands one word at a time to a downstream program sequencer and waits for that word's completion before it builds the next.

It keeps a running count of the request bytes that were actually written, and it abandons the request at the first failed word, reporting an I/O error. Byte order inside a word is little-endian: the lowest address sits in bits 7:0.

Top module: `byte_word_packer`

## Requirements
- R1: Every word request carries an address whose two low bits are 0. The first request goes to the start address with its two low bits cleared, and each later request is 4 above the one before it.
- R2: When the start address is unaligned with offset o (its low two bits), lanes 0 to o-1 of the first word hold 0xFF. Request byte i is placed in lane o+i while it fits.
- R3: Words that the request covers completely carry four request bytes unchanged. The earliest byte is in bits 7:0 and the latest is in bits 31:24.
- R4: A final word holding 1 to 3 request bytes carries them in its lowest lanes and 0xFF in every lane above them.
- R5: A request that starts and ends inside one word produces exactly one word request, padded with 0xFF both below and above the request bytes.
- R6: The byte count is cleared at start and grows after each successful word by only the number of request bytes in that word. It equals the length when a request completes without error.
- R7: A completion flagged as failed ends the request: `done` pulses with `io_err` = 1, no further word is requested, no further byte is accepted, and the count leaves out the failed word.
- R8: A zero-length start pulses `done` on the next cycle with `io_err` = 0 and count 0, and issues no word request.
- R9: A word request holds its address and data stable until it is accepted. The next word is not offered before the completion of the previous one.
- R10: After reset, `busy`, `done`, `in_ready`, `wr_valid` and `io_err` are 0 and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a request; taken only while idle |
| start_addr | input | AW | Byte address of the first request byte |
| len | input | LW | Number of request bytes |
| in_valid | input | 1 | Data byte offered |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | Packer takes the offered byte |
| wr_valid | output | 1 | Word request offered |
| wr_addr | output | AW | Word-aligned byte address of the request |
| wr_data | output | 32 | Packed word, little-endian |
| wr_ready | input | 1 | Sequencer takes the word request |
| wr_done | input | 1 | Completion of the accepted word |
| wr_err | input | 1 | With wr_done: the word failed |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse at the end of a request |
| io_err | output | 1 | The last request stopped on a failed word |
| count | output | LW | Request bytes written so far |

## Verification
The bench targets every combination of start offset and length residue. It includes requests that fit inside one word, which a design that padded only one side would corrupt. It also includes lengths that end exactly on a word boundary, where an off-by-one design would emit an extra all-ones word or drop the last one.

Failures are injected on the first, a middle and the last word. A design that kept going after a failure would show extra word requests or consume extra bytes. A design that counted the failed word or its padding would report a wrong byte count.

The sequencer's accept and completion timing is randomized. This catches a design that changes a pending word or offers the next word before the previous one completes.

// File: rtl/wpk_pkg.sv
// Shared definitions for the byte-to-word write packer.
package wpk_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_SEND,
        ST_WAIT,
        ST_DONE
    } wpk_state_t;
endpackage

// File: rtl/wpk_lane_fill.sv
// Word assembly register: one byte register per lane.
// Clearing sets every lane to all ones (the flash no-change value).
// A put writes one lane.
// Assumes clear and put never coincide (the controller guarantees it).
module wpk_lane_fill #(
    parameter int LANES  = 4,
    parameter int LANE_W = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clear,
    input  logic                                 put,
    input  logic [LANE_W-1:0]                    put_lane,
    input  logic [wpk_pkg::BYTE_W-1:0]           put_data,
    output logic [LANES*wpk_pkg::BYTE_W-1:0]     word
);
    import wpk_pkg::*;

    logic [BYTE_W-1:0] lane_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Hold one lane: reset/clear to padding, load on a matching put.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                lane_q[g] <= {BYTE_W{1'b1}};
            else if (put && put_lane == LANE_W'(g))
                lane_q[g] <= put_data;
        end
        assign word[g*BYTE_W +: BYTE_W] = lane_q[g];
    end
endmodule

// File: rtl/wpk_ctrl.sv
// Sequencing for the packer.
// It tracks the word address, the next lane, the bytes left and the real
// bytes in the current word. It runs the byte intake and the word handshake,
// and accumulates the written count.
// Assumes one outstanding word at a time and a completion per accepted word.
module wpk_ctrl #(
    parameter int AW     = 16,
    parameter int LW     = 12,
    parameter int LANES  = 4,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic [LW-1:0]     len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              wr_ready,
    input  logic              wr_done,
    input  logic              wr_err,
    output logic              wr_valid,
    output logic [AW-1:0]     wr_addr,
    output logic              word_clear,
    output logic              byte_put,
    output logic [LANE_W-1:0] put_lane,
    output logic              busy,
    output logic              done,
    output logic              io_err,
    output logic [LW-1:0]     count
);
    import wpk_pkg::*;

    wpk_state_t        state_q;
    logic [AW-1:0]     addr_q;
    logic [LANE_W-1:0] lane_q;
    logic [LW-1:0]     rem_q;
    logic [LANE_W:0]   wb_q;
    logic [LW-1:0]     count_q;
    logic              err_q;
    logic              take_start;
    logic              word_full;
    logic              next_word;

    assign take_start = (state_q == ST_IDLE) && start;
    assign byte_put   = (state_q == ST_FILL) && in_valid;
    assign word_full  = (lane_q == LANE_W'(LANES - 1)) || (rem_q == LW'(1));
    assign next_word  = (state_q == ST_WAIT) && wr_done && !wr_err && (rem_q != '0);
    assign word_clear = take_start || next_word;

    // State transitions of the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) state_q <= (len == '0) ? ST_DONE : ST_FILL;
                ST_FILL: if (in_valid && word_full) state_q <= ST_SEND;
                ST_SEND: if (wr_ready) state_q <= ST_WAIT;
                ST_WAIT: if (wr_done)
                             state_q <= (wr_err || rem_q == '0) ? ST_DONE : ST_FILL;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Word address, lane pointer, bytes left and bytes in this word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            lane_q <= '0;
            rem_q  <= '0;
            wb_q   <= '0;
        end else if (take_start) begin
            addr_q <= {start_addr[AW-1:LANE_W], {LANE_W{1'b0}}};
            lane_q <= start_addr[LANE_W-1:0];
            rem_q  <= len;
            wb_q   <= '0;
        end else if (byte_put) begin
            lane_q <= lane_q + 1'b1;
            rem_q  <= rem_q - 1'b1;
            wb_q   <= wb_q + 1'b1;
        end else if (next_word) begin
            addr_q <= addr_q + AW'(LANES);
            lane_q <= '0;
            wb_q   <= '0;
        end
    end

    // Written-byte count and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            err_q   <= 1'b0;
        end else if (take_start) begin
            count_q <= '0;
            err_q   <= 1'b0;
        end else if (state_q == ST_WAIT && wr_done) begin
            if (wr_err) err_q   <= 1'b1;
            else        count_q <= count_q + LW'(wb_q);
        end
    end

    assign in_ready = (state_q == ST_FILL);
    assign wr_valid = (state_q == ST_SEND);
    assign wr_addr  = addr_q;
    assign put_lane = lane_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);
    assign io_err   = err_q;
    assign count    = count_q;
endmodule

// File: rtl/byte_word_packer.sv
// Top of the byte-to-word write packer.
// It accepts a byte-granular write and issues aligned word program requests,
// padding uncovered lanes with 0xFF.
// Assumes the downstream sequencer returns exactly one completion per
// accepted word.
module byte_word_packer #(
    parameter int AW    = 16,
    parameter int LW    = 12,
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [AW-1:0]          start_addr,
    input  logic [LW-1:0]          len,
    input  logic                   in_valid,
    input  logic [7:0]             in_data,
    output logic                   in_ready,
    output logic                   wr_valid,
    output logic [AW-1:0]          wr_addr,
    output logic [LANES*8-1:0]     wr_data,
    input  logic                   wr_ready,
    input  logic                   wr_done,
    input  logic                   wr_err,
    output logic                   busy,
    output logic                   done,
    output logic                   io_err,
    output logic [LW-1:0]          count
);
    localparam int LANE_W = $clog2(LANES);

    logic              word_clear;
    logic              byte_put;
    logic [LANE_W-1:0] put_lane;

    wpk_ctrl #(.AW(AW), .LW(LW), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .len        (len),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .wr_ready   (wr_ready),
        .wr_done    (wr_done),
        .wr_err     (wr_err),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .word_clear (word_clear),
        .byte_put   (byte_put),
        .put_lane   (put_lane),
        .busy       (busy),
        .done       (done),
        .io_err     (io_err),
        .count      (count)
    );

    wpk_lane_fill #(.LANES(LANES), .LANE_W(LANE_W)) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (word_clear),
        .put      (byte_put),
        .put_lane (put_lane),
        .put_data (in_data),
        .word     (wr_data)
    );
endmodule

// File: rtl/wpk_chk.sv
// Protocol and behaviour checks for byte_word_packer, bound to the top.
module wpk_chk #(
    parameter int AW    = 16,
    parameter int LW    = 12,
    parameter int LANES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [LW-1:0]      len,
    input logic               in_ready,
    input logic               wr_valid,
    input logic [AW-1:0]      wr_addr,
    input logic [LANES*8-1:0] wr_data,
    input logic               wr_ready,
    input logic               wr_done,
    input logic               wr_err,
    input logic               busy,
    input logic               done,
    input logic               io_err,
    input logic [LW-1:0]      count
);
    localparam int LANE_W = $clog2(LANES);

    // R1
    wr_addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_addr[LANE_W-1:0] == '0);

    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R8
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && len == '0 |=> done && !io_err && count == '0);

    // R6
    count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> count >= $past(count));

    // R7
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_done && wr_err |=> done && io_err && !in_ready && !wr_valid);
endmodule

bind byte_word_packer wpk_chk #(.AW(AW), .LW(LW), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .len      (len),
    .in_ready (in_ready),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_ready (wr_ready),
    .wr_done  (wr_done),
    .wr_err   (wr_err),
    .busy     (busy),
    .done     (done),
    .io_err   (io_err),
    .count    (count)
);

// File: tb/sim_byte_word_packer.sv
module sim_byte_word_packer;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [LW-1:0] len = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic          wr_ready = 1'b0;
    logic          wr_done = 1'b0;
    logic          wr_err = 1'b0;
    logic          busy, done, io_err;
    logic [LW-1:0] count;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic [7:0]  src  [0:63];
    logic [31:0] got  [0:31];
    logic [AW-1:0] gota [0:31];

    byte_word_packer #(.AW(AW), .LW(LW), .LANES(4)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Expected word k of a request, computed from the lane rules.
    function automatic logic [31:0] exp_word(int a, int n, int k);
        logic [31:0] w;
        for (int l = 0; l < 4; l++) begin
            int p = 4*k + l - (a % 4);
            w[8*l +: 8] = (p >= 0 && p < n) ? src[p] : 8'hFF;
        end
        return w;
    endfunction

    function automatic int real_bytes(int a, int n, int k);
        int c = 0;
        for (int l = 0; l < 4; l++) begin
            int p = 4*k + l - (a % 4);
            if (p >= 0 && p < n) c++;
        end
        return c;
    endfunction

    function automatic string word_tag(int a, int n, int k, int nwt);
        if (nwt == 1) return "R5";
        if (k == 0 && (a % 4) != 0) return "R2";
        if (k == nwt - 1 && real_bytes(a, n, k) < 4) return "R4";
        return "R3";
    endfunction

    // Run one request; fail_at is the index of the failing word, -1 for none.
    task automatic run_case(input int a, input int n, input int fail_at);
        int idx = 0, nw = 0, dly = 0, cyc = 0;
        bit go = 0, pend = 0, fin = 0;
        int nwt, exp_nw, exp_cnt, exp_used;
        bit exp_err;
        for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
        nwt = (n == 0) ? 0 : ((a % 4) + n + 3) / 4;
        exp_err = (fail_at >= 0 && fail_at < nwt);
        exp_nw = exp_err ? fail_at + 1 : nwt;
        exp_cnt = 0;
        exp_used = 0;
        for (int k = 0; k < exp_nw; k++) begin
            exp_used += real_bytes(a, n, k);
            if (!(exp_err && k == fail_at)) exp_cnt += real_bytes(a, n, k);
        end

        @(negedge clk);
        start = 1'b1; start_addr = AW'(a); len = LW'(n);
        @(negedge clk);
        start = 1'b0;
        while (!fin && cyc < 3000) begin
            if (done) begin
                fin = 1;
                check(io_err == exp_err, "R7 io_err at done", io_err, exp_err);
                check(count == LW'(exp_cnt), "R6 byte count at done", count, exp_cnt);
            end
            if (go) idx++;
            if (wr_done) begin wr_done = 1'b0; wr_err = 1'b0; end
            if (pend) begin
                if (dly == 0) begin
                    wr_done = 1'b1;
                    wr_err = (fail_at == nw - 1);
                    pend = 0;
                end else dly--;
            end
            in_valid = (idx < n) && ($urandom % 4 != 0);
            in_data  = (idx < 64) ? src[idx] : 8'h00;
            go = in_valid && in_ready;
            wr_ready = ($urandom % 3 != 0);
            if (wr_valid && wr_ready) begin
                if (nw < 32) begin got[nw] = wr_data; gota[nw] = wr_addr; end
                nw++;
                pend = 1;
                dly = $urandom % 3;
            end
            cyc++;
            @(negedge clk);
        end
        in_valid = 1'b0; wr_ready = 1'b0; wr_done = 1'b0; wr_err = 1'b0;
        check(fin, "R9 request finished", fin, 1);
        check(nw == exp_nw, "R7 number of word requests", nw, exp_nw);
        check(idx == exp_used, "R7 bytes consumed", idx, exp_used);
        for (int k = 0; k < nw && k < exp_nw && k < 32; k++) begin
            int ea = (a & ~3) + 4*k;
            check(gota[k] == AW'(ea), "R1 word address", gota[k], ea);
            check(got[k] == exp_word(a, n, k),
                  {word_tag(a, n, k, nwt), " R9 word data"}, got[k], exp_word(a, n, k));
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!busy && !done && !in_ready && !wr_valid, "R10 idle outputs after reset",
              {busy, done, in_ready, wr_valid}, 0);
        check(!io_err && count == '0, "R10 io_err/count after reset", {io_err, count}, 0);

        // R8 zero length: done on the next cycle, no words
        run_case(5, 0, -1);

        // R5 single word, padding both sides
        run_case(1, 2, -1);
        run_case(2, 1, -1);
        run_case(0, 4, -1);

        // R2/R4 head and tail, boundary lengths
        run_case(3, 1, -1);
        run_case(3, 5, -1);
        run_case(1, 7, -1);
        run_case(2, 10, -1);
        run_case(8, 16, -1);
        run_case(4, 13, -1);

        // R7 failures on first, middle and last word
        run_case(2, 14, 0);
        run_case(1, 20, 2);
        run_case(0, 9, 2);

        // Random mix of all of the above
        for (int t = 0; t < 60; t++) begin
            int a = $urandom % 200;
            int n = $urandom % 48;
            int f = ($urandom % 4 == 0) ? int'($urandom % 8) : -1;
            run_case(a, n, f);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule